// File: doc/BRIEF.md
# Streaming Web and Ping Frame Classifier

This block sits in the path of an 8-bit byte stream of Ethernet frames and passes every frame to its output unchanged. The output is a straight copy of the input, with no register stage. While the bytes flow through, it watches the link header, the IPv4 header and the first bytes of the transport header. From these it decides whether each frame is web traffic (TCP, port 80), ping traffic (ICMP echo request or reply) or neither.

The transport header is found by following the IPv4 header-length field, so headers that carry options are handled. Two 32-bit counters keep the number of web frames and ping frames seen. Each counter steps once per frame, on the frame's last beat. A synchronous clear zeroes both counters and wins over an increment in the same cycle. The parser goes back to the start of a frame on the beat after a last beat, so frames may follow each other with no idle cycle.

Top module: `frame_tap_classifier`

## Requirements
- R1: Every byte accepted on the input appears on the output in the same cycle with the same value and the same last marker; nothing is added, dropped or reordered.
- R2: The input ready equals the output ready, so a stalled output holds the input and no byte is lost or duplicated.
- R3: A frame is web when bytes 12..13 hold 0x0800, the high nibble of byte 14 is 4, its low nibble (header words, IHL) is at least 5, byte 23 is 6, and either the 16-bit big-endian port at transport offset 0 or the one at offset 2 equals 80. A web frame raises the web count by 1.
- R4: A frame is ping when the IPv4 checks of R3 pass, byte 23 is 1, and the byte at transport offset 0 is 8 or 0. A ping frame raises the ping count by 1; other ICMP types count nothing.
- R5: A frame whose bytes 12..13 differ from 0x0800 (for example 0x0806) changes neither count.
- R6: The transport header starts at byte 14 + 4 × IHL. Bytes inside the IPv4 options are never taken as ports or ICMP type.
- R7: An IHL below 5 or a version other than 4 makes the frame neither.
- R8: A frame that ends before its deciding bytes arrive counts as neither: web needs bytes through transport offset 3, ping needs transport offset 0.
- R9: A clear input zeroes both counts on the next edge, and it wins over an increment that falls in the same cycle.
- R10: Counts change only at the edge that accepts a last beat. Back-to-back frames with no idle cycle are each classified on their own.
- R11: After reset both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 8 | Input byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input may advance |
| s_tlast | input | 1 | Input byte ends the frame |
| m_tdata | output | 8 | Output byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream accepts |
| m_tlast | output | 1 | Output byte ends the frame |
| cnt_clear | input | 1 | Zero both counts |
| web_count | output | 32 | Web frames counted |
| ping_count | output | 32 | Ping frames counted |

## Verification
The data path has no delay: each output byte is due in the same cycle its input is accepted. The bench records it at the accepting rising edge and compares the whole frame once the last beat has gone. The counts are due one edge after the accepting edge of the last beat, and a clear takes effect one edge after it is applied. The bench drives inputs on falling edges, so after a frame's last beat it reads the counts on the following falling edge, half a cycle after the update. With output stalls the last beat can land several cycles later, so each read waits for the actual accepting edge, not a fixed count.

// File: rtl/frame_tap_pkg.sv
// Shared constants and the header-field record for the frame classifier.
package frame_tap_pkg;
    localparam int          ETH_HDR_BYTES = 14;
    localparam logic [15:0] ETYPE_IPV4    = 16'h0800;
    localparam logic [3:0]  IP_VERSION    = 4'd4;
    localparam logic [3:0]  IHL_MIN       = 4'd5;
    localparam logic [7:0]  PROTO_TCP     = 8'd6;
    localparam logic [7:0]  PROTO_ICMP    = 8'd1;
    localparam logic [15:0] WEB_PORT      = 16'd80;
    localparam logic [7:0]  ICMP_ECHO_REQ = 8'd8;
    localparam logic [7:0]  ICMP_ECHO_REP = 8'd0;
    localparam int          POS_ETYPE_HI  = 12;
    localparam int          POS_ETYPE_LO  = 13;
    localparam int          POS_VER_IHL   = 14;
    localparam int          POS_PROTO     = 23;
    localparam int          TP_BYTES      = 4;

    // Fields gathered from one frame's headers
    typedef struct packed {
        logic [15:0]               etype;
        logic [3:0]                ver;
        logic [3:0]                ihl;
        logic [7:0]                proto;
        logic [TP_BYTES-1:0][7:0]  tp;    // transport bytes 0..3
    } hdr_fields_t;

    // Class index used to select a counter
    typedef enum logic [0:0] { CLS_WEB = 1'b0, CLS_PING = 1'b1 } cls_e;
    localparam int NUM_CLS = 2;
endpackage

// File: rtl/hdr_field_grab.sv
// Header field grabber.
// Tracks the byte index within the current frame and captures the link type,
// IPv4 version/IHL, protocol and the first four transport bytes. The transport
// position follows the IHL already captured. Assumes only accepted beats
// (beat=1) advance the index. Output fld is the field set including the byte of
// the current beat, so a decision on a last beat sees every byte.
module hdr_field_grab
    import frame_tap_pkg::*;
#(
    parameter int IDXW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            beat,
    input  logic            last,
    input  logic [7:0]      data,
    output logic [IDXW-1:0] idx,
    output hdr_fields_t     fld
);
    localparam logic [IDXW-1:0] IDX_MAX = '1;

    logic [IDXW-1:0] idx_q;
    hdr_fields_t     fld_q;
    logic [IDXW-1:0] tp_start;

    assign idx = idx_q;

    // Transport start from the IHL captured so far
    assign tp_start = IDXW'(ETH_HDR_BYTES) + IDXW'({fld_q.ihl, 2'b00});

    // Merge the current byte into the captured fields
    always_comb begin
        fld = fld_q;
        if (beat) begin
            if (idx_q == IDXW'(POS_ETYPE_HI)) fld.etype[15:8] = data;
            if (idx_q == IDXW'(POS_ETYPE_LO)) fld.etype[7:0]  = data;
            if (idx_q == IDXW'(POS_VER_IHL)) begin
                fld.ver = data[7:4];
                fld.ihl = data[3:0];
            end
            if (idx_q == IDXW'(POS_PROTO))    fld.proto       = data;
            for (int k = 0; k < TP_BYTES; k++) begin
                if (idx_q == tp_start + IDXW'(k)) fld.tp[k] = data;
            end
        end
    end

    // Advance index and store fields; restart after a last beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            fld_q <= '0;
        end else if (beat) begin
            if (last) begin
                idx_q <= '0;
                fld_q <= '0;
            end else begin
                fld_q <= fld;
                if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_class_decide.sv
// Frame class decision.
// Pure logic: from the field set and the index of the current byte, says whether
// a frame ending on this byte is web or ping. Assumes fld already holds the
// current byte. A frame too short to carry the deciding bytes is neither.
module frame_class_decide
    import frame_tap_pkg::*;
#(
    parameter int IDXW = 11
) (
    input  hdr_fields_t     fld,
    input  logic [IDXW-1:0] idx,
    output logic            is_web,
    output logic            is_ping
);
    logic [IDXW-1:0] tp_start;
    logic            ipv4_ok;
    logic [15:0]     port_a;
    logic [15:0]     port_b;

    assign tp_start = IDXW'(ETH_HDR_BYTES) + IDXW'({fld.ihl, 2'b00});
    assign port_a   = {fld.tp[0], fld.tp[1]};
    assign port_b   = {fld.tp[2], fld.tp[3]};

    // Link type, version and header length checks
    assign ipv4_ok = (fld.etype == ETYPE_IPV4) && (fld.ver == IP_VERSION)
                   && (fld.ihl >= IHL_MIN);

    // Web needs both port fields present
    assign is_web  = ipv4_ok && (fld.proto == PROTO_TCP)
                   && (idx >= tp_start + IDXW'(3))
                   && ((port_a == WEB_PORT) || (port_b == WEB_PORT));

    // Ping needs the type byte present
    assign is_ping = ipv4_ok && (fld.proto == PROTO_ICMP)
                   && (idx >= tp_start)
                   && ((fld.tp[0] == ICMP_ECHO_REQ) || (fld.tp[0] == ICMP_ECHO_REP));
endmodule

// File: rtl/pkt_event_counter.sv
// Wrapping event counter with synchronous clear.
// Clear wins over increment. Assumes inc is a one-cycle pulse per event.
module pkt_event_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count events, clear taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/frame_tap_classifier.sv
// Pass-through frame classifier (top).
// Forwards the byte stream unchanged with no register stage and counts web and
// ping frames on each frame's last beat. Assumes the upstream keeps tdata and
// tlast stable while valid is high and ready is low.
module frame_tap_classifier
    import frame_tap_pkg::*;
#(
    parameter int IDXW  = 11,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       s_tdata,
    input  logic             s_tvalid,
    output logic             s_tready,
    input  logic             s_tlast,
    output logic [7:0]       m_tdata,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic             m_tlast,
    input  logic             cnt_clear,
    output logic [CNT_W-1:0] web_count,
    output logic [CNT_W-1:0] ping_count
);
    logic                         beat;
    logic [IDXW-1:0]              idx;
    hdr_fields_t                  fld;
    logic                         is_web;
    logic                         is_ping;
    logic [NUM_CLS-1:0]           hit;
    logic [NUM_CLS-1:0][CNT_W-1:0] counts;

    // Straight-through data path
    assign m_tdata  = s_tdata;
    assign m_tvalid = s_tvalid;
    assign m_tlast  = s_tlast;
    assign s_tready = m_tready;
    assign beat     = s_tvalid && m_tready;

    hdr_field_grab #(.IDXW(IDXW)) u_grab (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (beat),
        .last  (s_tlast),
        .data  (s_tdata),
        .idx   (idx),
        .fld   (fld)
    );

    frame_class_decide #(.IDXW(IDXW)) u_decide (
        .fld     (fld),
        .idx     (idx),
        .is_web  (is_web),
        .is_ping (is_ping)
    );

    // One increment pulse per class on the last beat
    assign hit[CLS_WEB]  = beat && s_tlast && is_web;
    assign hit[CLS_PING] = beat && s_tlast && is_ping;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cnt
        pkt_event_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clear),
            .inc   (hit[c]),
            .count (counts[c])
        );
    end

    assign web_count  = counts[CLS_WEB];
    assign ping_count = counts[CLS_PING];
endmodule

// File: rtl/frame_tap_classifier_chk.sv
// Property checker for the frame classifier, bound to every instance.
module frame_tap_classifier_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_tvalid,
    input logic             s_tready,
    input logic             s_tlast,
    input logic             cnt_clear,
    input logic [CNT_W-1:0] web_count,
    input logic [CNT_W-1:0] ping_count
);
    // R11: reset leaves both counts at zero
    assert_reset_zero_R11: assert property (@(posedge clk)
        !rst_n |=> (web_count == '0) && (ping_count == '0));

    // R9: a clear zeroes both counts on the next edge
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (web_count == '0) && (ping_count == '0));

    // R10: counts move only after a last beat or a clear
    assert_web_on_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tvalid && s_tready && s_tlast) && !cnt_clear |=> $stable(web_count));
    assert_ping_on_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tvalid && s_tready && s_tlast) && !cnt_clear |=> $stable(ping_count));

    // R3: the web count steps by exactly one when it moves without a clear
    assert_web_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear && (s_tvalid && s_tready && s_tlast) |=>
            (web_count == $past(web_count)) || (web_count == $past(web_count) + 1'b1));

    // R4: a frame never counts as both web and ping
    assert_one_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear |=> !((web_count != $past(web_count)) && (ping_count != $past(ping_count))));
endmodule

bind frame_tap_classifier frame_tap_classifier_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_frame_tap_classifier.sv
`timescale 1ns/1ps
module tb_frame_tap_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic        s_tlast = 1'b0;
    logic [7:0]  m_tdata;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic        m_tlast;
    logic        cnt_clear = 1'b0;
    logic [31:0] web_count;
    logic [31:0] ping_count;

    int checks = 0;
    int failures = 0;
    int exp_web = 0;
    int exp_ping = 0;
    bit stall_on = 1'b0;
    int scnt = 0;

    logic [7:0] fb [0:127];
    int         flen;
    logic [7:0] rx_d [0:127];
    logic       rx_l [0:127];
    int         rx_n = 0;

    always #10 clk = ~clk;   // 50 MHz

    frame_tap_classifier dut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .cnt_clear(cnt_clear), .web_count(web_count), .ping_count(ping_count)
    );

    // Output ready pattern: open, or one cycle in three when stalling
    always @(negedge clk) begin
        scnt++;
        m_tready = stall_on ? (scnt % 3 == 0) : 1'b1;
    end

    // Record accepted output bytes
    always @(posedge clk) begin
        if (m_tvalid && m_tready && rx_n < 128) begin
            rx_d[rx_n] = m_tdata;
            rx_l[rx_n] = m_tlast;
            rx_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        chk(web_count == 32'(exp_web), {req, " web_count"}, int'(web_count), exp_web);
        chk(ping_count == 32'(exp_ping), {req, " ping_count"}, int'(ping_count), exp_ping);
    endtask

    // Build a frame; tp bytes: sp hi, sp lo, dp hi, dp lo; options hold 00 50 pairs
    task automatic build(input logic [15:0] et, input logic [3:0] ver, input logic [3:0] ihl,
                         input logic [7:0] proto, input logic [15:0] sp, input logic [15:0] dp,
                         input int len);
        int tofs = 14 + 4 * int'(ihl);
        for (int i = 0; i < 128; i++)
            fb[i] = (i >= 34 && i < tofs) ? ((i % 2) ? 8'h50 : 8'h00) : 8'(i * 3 + 1);
        fb[12] = et[15:8];
        fb[13] = et[7:0];
        fb[14] = {ver, ihl};
        fb[23] = proto;
        fb[tofs]   = sp[15:8];
        fb[tofs+1] = sp[7:0];
        fb[tofs+2] = dp[15:8];
        fb[tofs+3] = dp[7:0];
        flen = len;
    endtask

    // Send fb[0..flen-1]; called and returns at a falling edge
    task automatic send(input bit keep_valid, input bit clr_last, input string req);
        bit ok = 1'b1;
        rx_n = 0;
        for (int i = 0; i < flen; i++) begin
            s_tdata  = fb[i];
            s_tvalid = 1'b1;
            s_tlast  = (i == flen - 1);
            if (clr_last && i == flen - 1) cnt_clear = 1'b1;
            forever begin
                @(posedge clk);
                if (m_tready) break;
            end
            @(negedge clk);
            cnt_clear = 1'b0;
        end
        if (!keep_valid) begin
            s_tvalid = 1'b0;
            s_tlast  = 1'b0;
        end
        if (rx_n != flen) ok = 1'b0;
        for (int i = 0; i < flen && i < rx_n; i++)
            if (rx_d[i] !== fb[i] || rx_l[i] !== (i == flen - 1)) ok = 1'b0;
        chk(ok, {req, " bytes copied"}, rx_n, flen);
    endtask

    task automatic t_reset();
        chk_counts("R11");
        chk(s_tready == m_tready, "R2 ready follows", int'(s_tready), int'(m_tready));
    endtask

    task automatic t_web();
        build(16'h0800, 4, 5, 6, 16'd5000, 16'd80, 64); send(0, 0, "R1"); exp_web++; chk_counts("R3 dst80");
        build(16'h0800, 4, 5, 6, 16'd80, 16'd6000, 60); send(0, 0, "R1"); exp_web++; chk_counts("R3 src80");
        build(16'h0800, 4, 5, 6, 16'd8080, 16'd443, 60); send(0, 0, "R1"); chk_counts("R3 other port");
        build(16'h0800, 4, 5, 17, 16'd80, 16'd80, 60); send(0, 0, "R1"); chk_counts("R3 udp");
    endtask

    task automatic t_ping();
        build(16'h0800, 4, 5, 1, 16'h0800, 16'h1234, 60); send(0, 0, "R1"); exp_ping++; chk_counts("R4 request");
        build(16'h0800, 4, 5, 1, 16'h0000, 16'h1234, 60); send(0, 0, "R1"); exp_ping++; chk_counts("R4 reply");
        build(16'h0800, 4, 5, 1, 16'h0300, 16'h1234, 60); send(0, 0, "R1"); chk_counts("R4 type3");
    endtask

    task automatic t_nonip();
        build(16'h0806, 4, 5, 6, 16'd80, 16'd80, 60); send(0, 0, "R1"); chk_counts("R5 arp");
        build(16'h86DD, 4, 5, 1, 16'h0800, 16'd0, 60); send(0, 0, "R1"); chk_counts("R5 other type");
    endtask

    task automatic t_options();
        build(16'h0800, 4, 7, 6, 16'd1234, 16'd5678, 70); send(0, 0, "R1"); chk_counts("R6 decoy in options");
        build(16'h0800, 4, 15, 6, 16'd999, 16'd80, 90); send(0, 0, "R1"); exp_web++; chk_counts("R6 ihl15 web");
        build(16'h0800, 4, 6, 1, 16'h0800, 16'd0, 60); send(0, 0, "R1"); exp_ping++; chk_counts("R6 ihl6 ping");
    endtask

    task automatic t_bad_hdr();
        build(16'h0800, 6, 5, 6, 16'd80, 16'd80, 60); send(0, 0, "R1"); chk_counts("R7 version6");
        build(16'h0800, 4, 4, 6, 16'd80, 16'd80, 60); send(0, 0, "R1"); chk_counts("R7 ihl4");
    endtask

    task automatic t_trunc();
        build(16'h0800, 4, 5, 6, 16'd1000, 16'd80, 37); send(0, 0, "R1"); chk_counts("R8 web short");
        build(16'h0800, 4, 5, 6, 16'd1000, 16'd80, 38); send(0, 0, "R1"); exp_web++; chk_counts("R8 web exact");
        build(16'h0800, 4, 5, 1, 16'h0800, 16'd0, 34); send(0, 0, "R1"); chk_counts("R8 ping short");
        build(16'h0800, 4, 5, 1, 16'h0800, 16'd0, 35); send(0, 0, "R1"); exp_ping++; chk_counts("R8 ping exact");
    endtask

    task automatic t_stall();
        stall_on = 1'b1;
        build(16'h0800, 4, 5, 6, 16'd80, 16'd2000, 70); send(0, 0, "R2 stalled"); exp_web++;
        chk_counts("R2 stalled web");
        build(16'h0800, 4, 8, 1, 16'h0000, 16'd7, 66); send(0, 0, "R2 stalled"); exp_ping++;
        chk_counts("R2 stalled ping");
        stall_on = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_b2b();
        build(16'h0800, 4, 5, 6, 16'd3000, 16'd80, 40); send(1, 0, "R10 first"); exp_web++;
        build(16'h0800, 4, 5, 1, 16'h0800, 16'd1, 36); send(1, 0, "R10 second"); exp_ping++;
        build(16'h0806, 4, 5, 6, 16'd80, 16'd80, 42); send(0, 0, "R10 third");
        chk_counts("R10 back to back");
    endtask

    task automatic t_clear();
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
        exp_web = 0; exp_ping = 0;
        chk_counts("R9 clear");
        build(16'h0800, 4, 5, 6, 16'd80, 16'd1, 60); send(0, 0, "R1"); exp_web++; chk_counts("R9 count after clear");
        build(16'h0800, 4, 5, 6, 16'd80, 16'd1, 60); send(0, 1, "R9 clear on last");
        exp_web = 0; exp_ping = 0;
        chk_counts("R9 clear beats increment");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_web();
        t_ping();
        t_nonip();
        t_options();
        t_bad_hdr();
        t_trunc();
        t_stall();
        t_b2b();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule